// File: doc/BRIEF.md
# Multi-Mode Programmable Logic Cell Chain

This block is a row of identical programmable logic cells joined by two neighbour links: a carry link that ripples from the lowest-order cell to the highest, and a cascade link that merges each cell's result with the one before it. Every cell holds a 16-bit lookup table and one output register. A static mode field shared by all cells picks one of four behaviours: general logic, arithmetic, up/down counting, or counting with a synchronous clear. A set of static flag bits picks among further options. These options are the source of the third table input, whether the cascade merge is on and whether it is an AND or an OR, and whether each cell shows its combinational value or its register.

The configuration is written once by the surrounding system and then held stable while the clock runs. Data enters as four bits per cell, plus a carry and a cascade value for the first cell. Each cell returns one result bit. The final carry and cascade values leave the last cell. Wide decoders, ripple adders and loadable counters are all built from the same cell by choosing the table contents and the mode.

Top module: `lesl_slice`

## Requirements
- R1: In logic mode (mode 0), each cell's value is lut[idx] with idx = {d3, s, d1, d0}. Here s is d2 when cfg_cin_sel_i is 0 and the cell's carry-in when it is 1.
- R2: In logic and arithmetic modes, when cfg_casc_en_i is 1, each cell's value is its table bit ANDed with its cascade-in (cfg_casc_or_i = 0) or ORed with it (cfg_casc_or_i = 1). That merged value is the cell's cascade-out. Cell 0 takes casc_i, and casc_o is the last cell's cascade-out.
- R3: In arithmetic mode (mode 1), with k = {carry-in, d1, d0}, a cell's value is lut[k] (the low half) and its carry-out is lut[8+k] (the high half). A table of 16'hE896 in every cell makes the chain a ripple adder.
- R4: Cell 0 takes carry_i. Cell i+1 takes the carry-out of cell i. carry_o is the carry-out of the last cell.
- R5: In up/down mode (mode 2), the per-cell pins are d0 = load value, d1 = direction, d2 = load and d3 = count enable. With k = {carry-in, d1, Q}, the count bit is lut[k] and the carry-out is lut[8+k]. Load takes priority over count enable, and with neither set the register holds. A table of 16'h905A counts up when d1 = 1 and down when d1 = 0.
- R6: In clearable mode (mode 3), the cascade-in of every cell acts as an active-high synchronous clear. Clear beats load, and load beats count enable. The pin roles and table indexing are those of R5, and a table of 16'hA05A counts up.
- R7: When cfg_reg_out_i is 1, q_o shows the cell registers. In logic and arithmetic modes, the registers capture the combinational value on a clock edge where ena is 1.
- R8: While ena is 0, no cell register changes.
- R9: A low rst_n clears all registers at once. The internal reset is released on the second rising clock edge after rst_n rises.
- R10: In logic mode, each cell passes its carry-in unchanged to its carry-out. In both counter modes, each cell passes its cascade-in unchanged to its cascade-out, so casc_i clears the whole chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ena | input | 1 | Register enable for all cells |
| cfg_mode_i | input | 2 | Mode: 0 logic, 1 arithmetic, 2 up/down, 3 clearable |
| cfg_cin_sel_i | input | 1 | Logic mode: third table input is carry-in instead of d2 |
| cfg_casc_en_i | input | 1 | Merge table bit with cascade-in |
| cfg_casc_or_i | input | 1 | Cascade merge is OR (1) or AND (0) |
| cfg_reg_out_i | input | 1 | Cell output is the register (1) or the combinational value (0) |
| cfg_lut_i | input | 16*CELLS | Table of cell i at bits [16i+15:16i] |
| data_i | input | 4*CELLS | Data bits d3..d0 of cell i at bits [4i+3:4i] |
| carry_i | input | 1 | Carry into cell 0 |
| casc_i | input | 1 | Cascade into cell 0 |
| q_o | output | CELLS | Per-cell result |
| carry_o | output | 1 | Carry out of the last cell |
| casc_o | output | 1 | Cascade out of the last cell |

## Verification
The hardest situation to reach is a counter edge where clear, load and count enable are all active together. Just as hard is a ripple where the carry has to run through every cell, as in an all-ones count or 8'hFF plus 1. Random counter runs draw clear, load and enable with biased probabilities so that overlaps happen often. Directed steps force the triple overlap and the full-length carry. The wide decode test picks a hit pattern half of the time, because random data would almost never match all cells of an AND chain.

// File: rtl/lesl_pkg.sv
package lesl_pkg;
  typedef enum logic [1:0] {
    LM_LOGIC  = 2'd0,
    LM_ARITH  = 2'd1,
    LM_UPDN   = 2'd2,
    LM_CLRCNT = 2'd3
  } lesl_mode_e;

  localparam int unsigned LUT_BITS = 16;
  localparam int unsigned DIN_BITS = 4;

  // per-cell static option flags shared across the chain
  typedef struct packed {
    logic cin_sel;
    logic casc_en;
    logic casc_or;
    logic reg_out;
  } lesl_flags_t;
endpackage

// File: rtl/lesl_table.sv
module lesl_table
  import lesl_pkg::*;
(
  input  logic [LUT_BITS-1:0] lut_i,
  input  logic [3:0]          idx4_i,
  input  logic [2:0]          idx3_i,
  output logic                full_o,
  output logic                low_o,
  output logic                high_o
);
  // full 4-input read for logic mode, split halves for carry modes
  always_comb begin
    full_o = lut_i[idx4_i];
    low_o  = lut_i[{1'b0, idx3_i}];
    high_o = lut_i[{1'b1, idx3_i}];
  end
endmodule

// File: rtl/lesl_cell.sv
module lesl_cell
  import lesl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  lesl_mode_e          mode_i,
  input  lesl_flags_t         flags_i,
  input  logic [LUT_BITS-1:0] lut_i,
  input  logic [DIN_BITS-1:0] d_i,
  input  logic                cin_i,
  input  logic                cascin_i,
  output logic                cout_o,
  output logic                cascout_o,
  output logic                q_o
);
  logic       q_r, q_nxt;
  logic [3:0] idx4;
  logic [2:0] idx3;
  logic       t_full, t_low, t_high;
  logic       base, merged, comb;
  logic       is_cnt, ld_mux, hold, clr;

  assign is_cnt = (mode_i == LM_UPDN) || (mode_i == LM_CLRCNT);

  always_comb begin
    idx4 = {d_i[3], (flags_i.cin_sel ? cin_i : d_i[2]), d_i[1], d_i[0]};
    idx3 = is_cnt ? {cin_i, d_i[1], q_r} : {cin_i, d_i[1], d_i[0]};
  end

  lesl_table u_tab (
    .lut_i  (lut_i),
    .idx4_i (idx4),
    .idx3_i (idx3),
    .full_o (t_full),
    .low_o  (t_low),
    .high_o (t_high)
  );

  // combinational value and neighbour links
  always_comb begin
    base   = (mode_i == LM_LOGIC) ? t_full : t_low;
    merged = flags_i.casc_or ? (base | cascin_i) : (base & cascin_i);
    if (is_cnt) begin
      comb      = t_low;
      cascout_o = cascin_i;
    end else begin
      comb      = flags_i.casc_en ? merged : base;
      cascout_o = comb;
    end
    cout_o = (mode_i == LM_LOGIC) ? cin_i : t_high;
  end

  // next-state: clear > load > count enable > hold
  always_comb begin
    clr    = (mode_i == LM_CLRCNT) && cascin_i;
    ld_mux = d_i[2] ? d_i[0] : t_low;
    hold   = !d_i[2] && !d_i[3];
    if (is_cnt) begin
      if (clr)       q_nxt = 1'b0;
      else if (hold) q_nxt = q_r;
      else           q_nxt = ld_mux;
    end else begin
      q_nxt = comb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= 1'b0;
    else if (en) q_r <= q_nxt;
  end

  assign q_o = flags_i.reg_out ? q_r : comb;

  // R8: register frozen without enable
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q_r));

  // R6: synchronous clear through the cascade slot wins
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode_i == LM_CLRCNT && cascin_i) |=> (q_r == 1'b0));

  // R5: load captures d0 in the counter modes
  a_r5_load_takes_d0: assert property (@(posedge clk) disable iff (!rst_n)
    (en && is_cnt && d_i[2] && !clr) |=> (q_r == $past(d_i[0])));
endmodule

// File: rtl/lesl_slice.sv
module lesl_slice
  import lesl_pkg::*;
#(
  parameter int unsigned CELLS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ena,
  input  logic [1:0]                 cfg_mode_i,
  input  logic                       cfg_cin_sel_i,
  input  logic                       cfg_casc_en_i,
  input  logic                       cfg_casc_or_i,
  input  logic                       cfg_reg_out_i,
  input  logic [CELLS*LUT_BITS-1:0]  cfg_lut_i,
  input  logic [CELLS*DIN_BITS-1:0]  data_i,
  input  logic                       carry_i,
  input  logic                       casc_i,
  output logic [CELLS-1:0]           q_o,
  output logic                       carry_o,
  output logic                       casc_o
);
  localparam int unsigned LINKS = CELLS + 1;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [LINKS-1:0] cy;
  logic [LINKS-1:0] cs;
  lesl_mode_e       mode;
  lesl_flags_t      flags;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign mode  = lesl_mode_e'(cfg_mode_i);
  assign flags = '{cin_sel: cfg_cin_sel_i, casc_en: cfg_casc_en_i,
                   casc_or: cfg_casc_or_i, reg_out: cfg_reg_out_i};

  assign cy[0] = carry_i;
  assign cs[0] = casc_i;

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    lesl_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .en        (ena),
      .mode_i    (mode),
      .flags_i   (flags),
      .lut_i     (cfg_lut_i[i*LUT_BITS +: LUT_BITS]),
      .d_i       (data_i[i*DIN_BITS +: DIN_BITS]),
      .cin_i     (cy[i]),
      .cascin_i  (cs[i]),
      .cout_o    (cy[i+1]),
      .cascout_o (cs[i+1]),
      .q_o       (q_o[i])
    );
  end

  assign carry_o = cy[CELLS];
  assign casc_o  = cs[CELLS];

  // R10: logic mode forwards the carry through the whole chain
  a_r10_carry_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode_i == 2'd0) |-> (carry_o == carry_i));
endmodule

// File: tb/sim_lesl_slice.sv
module sim_lesl_slice;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n, ena;
  logic [1:0] mode;
  logic cin_sel, casc_en, casc_or, reg_out;
  logic [N*16-1:0] lut;
  logic [N*4-1:0] data;
  logic carry_i, casc_i;
  logic [N-1:0] q;
  logic carry_o, casc_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  lesl_slice #(.CELLS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .ena(ena), .cfg_mode_i(mode),
    .cfg_cin_sel_i(cin_sel), .cfg_casc_en_i(casc_en), .cfg_casc_or_i(casc_or),
    .cfg_reg_out_i(reg_out), .cfg_lut_i(lut), .data_i(data),
    .carry_i(carry_i), .casc_i(casc_i), .q_o(q), .carry_o(carry_o), .casc_o(casc_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // combinational model of logic/arith chain: {casc, carry, q}
  function automatic logic [N+1:0] mdl_comb(input logic arith);
    logic c, k, b, m;
    logic [3:0] d4;
    logic [15:0] t;
    logic [N-1:0] r;
    logic [3:0] ix;
    c = carry_i; k = casc_i; r = '0;
    for (int i = 0; i < N; i++) begin
      d4 = data[4*i +: 4];
      t  = lut[16*i +: 16];
      if (!arith) begin
        ix = {d4[3], (cin_sel ? c : d4[2]), d4[1], d4[0]};
        b  = t[ix];
      end else begin
        ix = {1'b0, c, d4[1], d4[0]};
        b  = t[ix];
        c  = t[ix + 4'd8];
      end
      m = casc_en ? (casc_or ? (b | k) : (b & k)) : b;
      r[i] = m;
      k = m;
    end
    return {k, c, r};
  endfunction

  function automatic logic [N*4-1:0] cnt_data(input logic cen, input logic ld,
                                               input logic dir, input logic [N-1:0] v);
    logic [N*4-1:0] x;
    for (int i = 0; i < N; i++) x[4*i +: 4] = {cen, ld, dir, v[i]};
    return x;
  endfunction

  task automatic set_all_lut(input logic [15:0] t);
    for (int i = 0; i < N; i++) lut[16*i +: 16] = t;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N+1:0] e;
    logic [N-1:0] a, b, cval, ld;
    logic [8:0] s;
    logic cl, lo, en, dr;
    void'($urandom(32'd1234));
    rst_n = 1'b0; ena = 1'b1; mode = 2'd1; cin_sel = 0; casc_en = 0; casc_or = 0;
    reg_out = 1'b1; set_all_lut(16'hE896); data = '1; carry_i = 1; casc_i = 1;
    repeat (3) @(negedge clk);
    chk("R9 reset clears registers", q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 held through first edge after release", q, 0);
    repeat (3) @(negedge clk);

    // R1 logic mode, both third-input sources
    mode = 2'd0; reg_out = 0;
    for (int s2 = 0; s2 < 2; s2++) begin
      cin_sel = s2[0];
      for (int n = 0; n < 30; n++) begin
        @(negedge clk);
        for (int i = 0; i < N; i++) lut[16*i +: 16] = $urandom;
        data = {$urandom, $urandom}; carry_i = $urandom;
        #1 e = mdl_comb(0);
        chk("R1 logic table", q, e[N-1:0]);
        chk("R10 carry passes in logic mode", carry_o, carry_i);
      end
    end

    // R2 wide AND decode and OR merge
    cin_sel = 0; casc_en = 1;
    for (int o = 0; o < 2; o++) begin
      casc_or = o[0];
      for (int n = 0; n < 30; n++) begin
        @(negedge clk);
        a = $urandom; b = $urandom;
        for (int i = 0; i < N; i++) lut[16*i +: 16] = 16'h0001 << ((a[i] ? 4'd15 : 4'd0) ^ {3'b0, b[i]});
        data = '0;
        if ($urandom_range(1)) for (int i = 0; i < N; i++)
          data[4*i +: 4] = (a[i] ? 4'd15 : 4'd0) ^ {3'b0, b[i]};
        else data = {$urandom, $urandom};
        casc_i = o[0] ? ($urandom_range(3) == 0) : 1'b1;
        #1 e = mdl_comb(0);
        chk("R2 cascade chain out", casc_o, e[N+1]);
        chk("R2 cascade cell values", q, e[N-1:0]);
      end
    end
    casc_en = 0; casc_or = 0;

    // R3/R4 ripple adder, random plus full-length carries
    mode = 2'd1; set_all_lut(16'hE896);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      if (n == 0) begin a = 8'hFF; b = 8'h01; carry_i = 0; end
      else if (n == 1) begin a = 8'hFF; b = 8'hFF; carry_i = 1; end
      else if (n == 2) begin a = 8'h00; b = 8'hFF; carry_i = 1; end
      else begin a = $urandom; b = $urandom; carry_i = $urandom; end
      for (int i = 0; i < N; i++) data[4*i +: 4] = {2'b00, b[i], a[i]};
      s = {1'b0, a} + {1'b0, b} + {8'b0, carry_i};
      #1;
      chk("R3 adder sum", q, s[7:0]);
      chk("R4 final carry", carry_o, s[8]);
    end

    // R7 registered arithmetic, R8 hold without enable
    reg_out = 1;
    @(negedge clk);
    a = 8'h5C; b = 8'h27; carry_i = 0;
    for (int i = 0; i < N; i++) data[4*i +: 4] = {2'b00, b[i], a[i]};
    @(negedge clk);
    chk("R7 register captures sum", q, 8'h83);
    ena = 0; a = 8'h11; b = 8'h22;
    for (int i = 0; i < N; i++) data[4*i +: 4] = {2'b00, b[i], a[i]};
    repeat (2) @(negedge clk);
    chk("R8 hold while ena low", q, 8'h83);
    ena = 1;

    // R5 up/down counter
    mode = 2'd2; set_all_lut(16'h905A); carry_i = 1; casc_i = 0;
    data = cnt_data(1, 1, 1, 8'hFE); cval = 8'hFE;
    @(negedge clk);
    chk("R5 load", q, cval);
    for (int n = 0; n < 80; n++) begin
      lo = ($urandom_range(7) == 0); en = $urandom_range(3) != 0; dr = $urandom;
      ld = $urandom;
      if (n == 2) begin lo = 0; en = 1; dr = 1; cval = cval; end
      data = cnt_data(en, lo, dr, ld);
      if (lo) cval = ld; else if (en) cval = dr ? cval + 1 : cval - 1;
      @(negedge clk);
      chk("R5 up/down count", q, cval);
    end
    data = cnt_data(1, 1, 0, 8'h00); cval = 0;
    @(negedge clk);
    data = cnt_data(1, 0, 0, 8'h00); cval = 8'hFF;
    @(negedge clk);
    chk("R5 down wrap through all cells", q, cval);

    // R6 clearable counter, R10 cascade pass-through
    mode = 2'd3; set_all_lut(16'hA05A);
    for (int n = 0; n < 80; n++) begin
      cl = ($urandom_range(7) == 0); lo = ($urandom_range(5) == 0);
      en = $urandom_range(3) != 0; ld = $urandom;
      if (n == 5) begin cl = 1; lo = 1; en = 1; end
      if (n == 6) begin cl = 0; lo = 1; en = 1; ld = 8'hFF; end
      casc_i = cl;
      data = cnt_data(en, lo, $urandom, ld);
      #1 chk("R10 cascade passes in counter mode", casc_o, cl);
      if (cl) cval = 0; else if (lo) cval = ld; else if (en) cval = cval + 1;
      @(negedge clk);
      chk("R6 clearable count", q, cval);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule